// File: doc/BRIEF.md
# Iterative Decoder Stopping Controller

This block tells an iterative two-pass soft decoder when to stop. Each iteration of the decoder is made of two constituent MAP passes. After each pass the decoder sends a one-cycle completion pulse with an extrinsic SNR estimate, and the controller makes its stop decision at that pulse. During each iteration the decoder also streams that iteration's hard-decision bits into the controller. The bits may come as several sub-blocks separated by idle gaps. The controller runs a CRC over them with a programmable polynomial and length. It keeps a count of how many iterations in a row ended with a passing CRC.

Four rules decide the stop:
- The SNR threshold test.
- The consecutive-CRC-pass test.
- The maximum-iteration limit.
- A minimum iteration count that holds off both early-stop tests.

The SNR, CRC and maximum-iteration tests can each be enabled on their own. When the controller stops, it raises a held stop flag and a one-cycle done pulse, and it latches a 2-bit stop reason. It holds this state until the next start. It also reports the latest CRC result, the latest SNR comparison, the active iteration number, and a configuration error when the minimum iteration count is above the maximum.

The hard-decision input is a valid/ready stream. A bit is consumed on a cycle where both `hd_valid_i` and `hd_ready_o` are high. The block drops ready to refuse bits only when it is not running, that is before the first start and after a stop. A source may leave valid low for any number of cycles, including between sub-blocks, without disturbing the CRC.

Top module: `iter_stop_ctrl`

## Requirements
- R1: A start pulse sets the active iteration to 1. Every second accepted pass pulse that does not stop the block advances it by one, saturating at its maximum value. The stop rules are evaluated at every pass pulse.
- R2: With the SNR test enabled, a pass whose SNR estimate is strictly greater than the unsigned threshold stops the block with reason 01, provided the minimum-iteration rule allows it. An estimate equal to the threshold does not stop the block.
- R3: No SNR or CRC stop happens while the active iteration number is below the programmed minimum (valid range 1 to 31).
- R4: With the maximum test enabled, the second pass of an iteration whose number is at or above the programmed maximum stops the block with reason 11, if no higher-priority rule fired.
- R5: The CRC register is cleared at start and after each frame's last bit. Bits enter MSB-first. For each bit, feedback = register[len-1] XOR bit, and the register becomes (register shifted left by one) XOR (polynomial if feedback is 1), masked to len bits. A frame passes when the register is zero after its last bit, which happens when the frame ends with its len-bit remainder sent MSB-first. A len of 0 or above 32 acts as 32.
- R6: The CRC state is carried across idle cycles and sub-block boundaries. Only the bit marked last ends a frame.
- R7: A passing frame increments a saturating consecutive-pass count and a failing frame clears it to zero. With the CRC test enabled, a stop with reason 10 needs a count that is nonzero and at least the programmed requirement.
- R8: The stop reason is 00 none, 01 SNR, 10 CRC, 11 maximum. When several rules hold at the same pass, SNR wins over CRC and CRC wins over maximum. The reason is nonzero whenever the stop flag is set.
- R9: The done pulse is high for exactly one cycle, in the cycle after the stopping pass pulse, which is also the cycle the stop flag rises. The stop flag, reason and iteration number then hold, and further pass pulses are ignored, until the next start.
- R10: `crc_pass_o` gives the result of the most recent frame. `snr_exceed_o` gives the comparison made at the most recent accepted pass. Both are cleared at start.
- R11: `cfg_err_o` is high one cycle after the minimum iteration input is above the maximum iteration input, and low otherwise.
- R12: A disabled test never causes a stop, whatever its inputs show.
- R13: `hd_ready_o` is high exactly while the block is running, from the cycle after start until a stop. Bits offered while it is low are not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new frame, clearing all decision state |
| min_iter_i | input | ITER_W | Minimum iteration count before an early stop |
| max_iter_i | input | ITER_W | Iteration limit for the maximum test |
| en_snr_i | input | 1 | Enable SNR stop test |
| en_crc_i | input | 1 | Enable CRC stop test |
| en_max_i | input | 1 | Enable maximum-iteration stop test |
| snr_thr_i | input | SNR_W | SNR threshold, unsigned |
| crc_poly_i | input | CRC_W | CRC generator polynomial, low len bits used |
| crc_len_i | input | LEN_W | CRC length in bits |
| crc_need_i | input | NEED_W | Consecutive passing iterations needed for a CRC stop |
| pass_done_i | input | 1 | One-cycle pulse at the end of each MAP pass |
| pass_snr_i | input | SNR_W | Extrinsic SNR estimate for the finished pass |
| hd_valid_i | input | 1 | Hard-decision bit valid |
| hd_ready_o | output | 1 | Hard-decision bit accepted when high |
| hd_bit_i | input | 1 | Hard-decision bit |
| hd_last_i | input | 1 | Marks the final bit of the iteration's frame |
| stop_o | output | 1 | Held stop flag |
| done_o | output | 1 | One-cycle pulse when the stop is declared |
| reason_o | output | 2 | Stop reason code |
| crc_pass_o | output | 1 | Most recent frame passed its CRC |
| snr_exceed_o | output | 1 | Most recent pass estimate was above the threshold |
| act_iter_o | output | ITER_W | Active iteration number |
| cfg_err_o | output | 1 | Minimum iterations above maximum |

## Verification
The bench builds the block with its default parameters. These are an 8-bit SNR estimate, a 5-bit iteration counter, a 32-bit CRC polynomial register and a 3-bit consecutive-pass requirement. With them the bench can use the full 31-iteration range, CRC lengths of 8, 16 and the full 32 bits, and pass requirements up to 7. It covers streams split into sub-blocks with idle gaps, the threshold-equality boundary, the limit case where the maximum is 1, and the priority between SNR and CRC when both fire at the same pass.

// File: rtl/iter_stop_pkg.sv
package iter_stop_pkg;
  typedef enum logic [1:0] {
    WHY_NONE = 2'b00,
    WHY_SNR  = 2'b01,
    WHY_CRC  = 2'b10,
    WHY_MAX  = 2'b11
  } stop_why_e;
endpackage

// File: rtl/isc_crc_serial.sv
// Serial CRC over one iteration's hard decisions plus consecutive-pass run counter.
module isc_crc_serial #(
  parameter int CRC_W  = 32,
  parameter int LEN_W  = 6,
  parameter int NEED_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              last_i,
  input  logic [CRC_W-1:0]  poly_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [NEED_W-1:0] need_i,
  output logic              crc_pass_o,
  output logic              need_met_o
);
  localparam logic [NEED_W-1:0] RUN_SAT = '1;

  logic [LEN_W-1:0]  len_eff;
  logic [CRC_W-1:0]  mask;
  logic [CRC_W-1:0]  rem_q, rem_nxt;
  logic [NEED_W-1:0] run_q;
  logic              pass_q;
  logic              top_bit, fb;
  logic              acc;

  assign acc = bit_vld_i && !clr_i;

  always_comb begin
    if (len_i == '0 || len_i > LEN_W'(CRC_W)) len_eff = LEN_W'(CRC_W);
    else                                      len_eff = len_i;
  end

  // Active-length mask, one bit per register stage
  for (genvar i = 0; i < CRC_W; i++) begin : g_mask
    assign mask[i] = (LEN_W'(i) < len_eff);
  end

  // Select the current top stage without a variable-width index
  always_comb begin
    top_bit = 1'b0;
    for (int i = 0; i < CRC_W; i++) begin
      if (LEN_W'(i + 1) == len_eff) top_bit = rem_q[i];
    end
  end

  assign fb      = top_bit ^ bit_i;
  assign rem_nxt = ({rem_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & poly_i)) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      run_q  <= '0;
      pass_q <= 1'b0;
    end else if (clr_i) begin
      rem_q  <= '0;
      run_q  <= '0;
      pass_q <= 1'b0;
    end else if (acc) begin
      if (last_i) begin
        rem_q  <= '0;
        pass_q <= (rem_nxt == '0);
        if (rem_nxt == '0) run_q <= (run_q == RUN_SAT) ? run_q : run_q + 1'b1;
        else               run_q <= '0;
      end else begin
        rem_q <= rem_nxt;
      end
    end
  end

  assign crc_pass_o = pass_q;
  assign need_met_o = (run_q != '0) && (run_q >= need_i);

  // After a frame ends, the run count is nonzero exactly when the frame passed
  assert_run_tracks_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last_i) |=> (pass_q == (run_q != '0)));

  // Register is zero at the start of every new frame
  assert_rem_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last_i) |=> (rem_q == '0));

  // Idle cycles between sub-blocks leave the CRC state untouched
  assert_gap_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld_i && !clr_i) |=> $stable(rem_q));
endmodule

// File: rtl/isc_iter_track.sv
// Active iteration number and pass-within-iteration tracking.
module isc_iter_track #(
  parameter int ITER_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              advance_i,
  output logic [ITER_W-1:0] act_iter_o,
  output logic              second_o
);
  localparam logic [ITER_W-1:0] ITER_SAT = '1;

  logic [ITER_W-1:0] iter_q;
  logic              half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q <= '0;
      half_q <= 1'b0;
    end else if (start_i) begin
      iter_q <= ITER_W'(1);
      half_q <= 1'b0;
    end else if (advance_i) begin
      half_q <= ~half_q;
      if (half_q && iter_q != ITER_SAT) iter_q <= iter_q + 1'b1;
    end
  end

  assign act_iter_o = iter_q;
  assign second_o   = half_q;

  assert_iter_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (iter_q == $past(iter_q)) || (iter_q == $past(iter_q) + ITER_W'(1)));

  assert_half_flips_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !start_i) |=> (half_q != $past(half_q)));
endmodule

// File: rtl/isc_stop_rules.sv
// Applies the stop rules at each pass pulse and holds the outcome.
module isc_stop_rules
  import iter_stop_pkg::*;
#(
  parameter int ITER_W = 5,
  parameter int SNR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pass_done_i,
  input  logic [SNR_W-1:0]  pass_snr_i,
  input  logic [SNR_W-1:0]  snr_thr_i,
  input  logic              en_snr_i,
  input  logic              en_crc_i,
  input  logic              en_max_i,
  input  logic [ITER_W-1:0] min_iter_i,
  input  logic [ITER_W-1:0] max_iter_i,
  input  logic [ITER_W-1:0] act_iter_i,
  input  logic              second_i,
  input  logic              crc_met_i,
  output logic              run_o,
  output logic              stop_now_o,
  output logic              stop_o,
  output logic              done_o,
  output logic [1:0]        reason_o,
  output logic              snr_exceed_o,
  output logic              cfg_err_o
);
  stop_why_e why, why_q;
  logic run_q, stop_q, done_q, snr_q, cfg_q;
  logic min_ok, snr_hi, hit_snr, hit_crc, hit_max;

  assign min_ok  = (act_iter_i >= min_iter_i);
  assign snr_hi  = (pass_snr_i > snr_thr_i);
  assign hit_snr = en_snr_i && snr_hi && min_ok;
  assign hit_crc = en_crc_i && crc_met_i && min_ok;
  assign hit_max = en_max_i && second_i && (act_iter_i >= max_iter_i);

  // Fixed priority: SNR, then CRC, then iteration limit
  always_comb begin
    if      (hit_snr) why = WHY_SNR;
    else if (hit_crc) why = WHY_CRC;
    else if (hit_max) why = WHY_MAX;
    else              why = WHY_NONE;
  end

  assign stop_now_o = pass_done_i && run_q && !start_i && (why != WHY_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
      why_q  <= WHY_NONE;
      snr_q  <= 1'b0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      stop_q <= 1'b0;
      done_q <= 1'b0;
      why_q  <= WHY_NONE;
      snr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pass_done_i && run_q) begin
        snr_q <= snr_hi;
        if (stop_now_o) begin
          run_q  <= 1'b0;
          stop_q <= 1'b1;
          done_q <= 1'b1;
          why_q  <= why;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= 1'b0;
    else        cfg_q <= (min_iter_i > max_iter_i);
  end

  assign run_o        = run_q;
  assign stop_o       = stop_q;
  assign done_o       = done_q;
  assign reason_o     = why_q;
  assign snr_exceed_o = snr_q;
  assign cfg_err_o    = cfg_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_stop_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !start_i) |=> (stop_q && $stable(why_q)));

  assert_reason_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (why_q != WHY_NONE));

  assert_early_after_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (why_q == WHY_SNR || why_q == WHY_CRC)) |-> ($past(act_iter_i) >= $past(min_iter_i)));

  assert_run_excl_stop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && stop_q));
endmodule

// File: rtl/iter_stop_ctrl.sv
// Top: stopping controller for an iterative two-pass soft decoder.
module iter_stop_ctrl #(
  parameter  int SNR_W  = 8,
  parameter  int ITER_W = 5,
  parameter  int CRC_W  = 32,
  parameter  int NEED_W = 3,
  localparam int LEN_W  = $clog2(CRC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ITER_W-1:0] min_iter_i,
  input  logic [ITER_W-1:0] max_iter_i,
  input  logic              en_snr_i,
  input  logic              en_crc_i,
  input  logic              en_max_i,
  input  logic [SNR_W-1:0]  snr_thr_i,
  input  logic [CRC_W-1:0]  crc_poly_i,
  input  logic [LEN_W-1:0]  crc_len_i,
  input  logic [NEED_W-1:0] crc_need_i,
  input  logic              pass_done_i,
  input  logic [SNR_W-1:0]  pass_snr_i,
  input  logic              hd_valid_i,
  output logic              hd_ready_o,
  input  logic              hd_bit_i,
  input  logic              hd_last_i,
  output logic              stop_o,
  output logic              done_o,
  output logic [1:0]        reason_o,
  output logic              crc_pass_o,
  output logic              snr_exceed_o,
  output logic [ITER_W-1:0] act_iter_o,
  output logic              cfg_err_o
);
  logic              run, stop_now, second, crc_met;
  logic [ITER_W-1:0] act_iter;

  isc_crc_serial #(.CRC_W(CRC_W), .LEN_W(LEN_W), .NEED_W(NEED_W)) u_crc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_i),
    .bit_vld_i  (hd_valid_i && run),
    .bit_i      (hd_bit_i),
    .last_i     (hd_last_i),
    .poly_i     (crc_poly_i),
    .len_i      (crc_len_i),
    .need_i     (crc_need_i),
    .crc_pass_o (crc_pass_o),
    .need_met_o (crc_met)
  );

  isc_iter_track #(.ITER_W(ITER_W)) u_iter (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .advance_i  (pass_done_i && run && !stop_now),
    .act_iter_o (act_iter),
    .second_o   (second)
  );

  isc_stop_rules #(.ITER_W(ITER_W), .SNR_W(SNR_W)) u_rules (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pass_done_i  (pass_done_i),
    .pass_snr_i   (pass_snr_i),
    .snr_thr_i    (snr_thr_i),
    .en_snr_i     (en_snr_i),
    .en_crc_i     (en_crc_i),
    .en_max_i     (en_max_i),
    .min_iter_i   (min_iter_i),
    .max_iter_i   (max_iter_i),
    .act_iter_i   (act_iter),
    .second_i     (second),
    .crc_met_i    (crc_met),
    .run_o        (run),
    .stop_now_o   (stop_now),
    .stop_o       (stop_o),
    .done_o       (done_o),
    .reason_o     (reason_o),
    .snr_exceed_o (snr_exceed_o),
    .cfg_err_o    (cfg_err_o)
  );

  assign hd_ready_o = run;
  assign act_iter_o = act_iter;

  // A stop always freezes the iteration number it was declared at
  assert_iter_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !start_i) |=> $stable(act_iter));
endmodule

// File: tb/iter_stop_ctrl_tb_top.sv
module iter_stop_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  min_iter_i = 5'd1, max_iter_i = 5'd8;
  logic        en_snr_i = 1'b0, en_crc_i = 1'b0, en_max_i = 1'b0;
  logic [7:0]  snr_thr_i = 8'd100;
  logic [31:0] crc_poly_i = 32'h07;
  logic [5:0]  crc_len_i = 6'd8;
  logic [2:0]  crc_need_i = 3'd1;
  logic        pass_done_i = 1'b0;
  logic [7:0]  pass_snr_i = 8'd0;
  logic        hd_valid_i = 1'b0, hd_bit_i = 1'b0, hd_last_i = 1'b0;
  logic        hd_ready_o, stop_o, done_o, crc_pass_o, snr_exceed_o, cfg_err_o;
  logic [1:0]  reason_o;
  logic [4:0]  act_iter_o;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  iter_stop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .min_iter_i(min_iter_i), .max_iter_i(max_iter_i),
    .en_snr_i(en_snr_i), .en_crc_i(en_crc_i), .en_max_i(en_max_i),
    .snr_thr_i(snr_thr_i), .crc_poly_i(crc_poly_i), .crc_len_i(crc_len_i),
    .crc_need_i(crc_need_i), .pass_done_i(pass_done_i), .pass_snr_i(pass_snr_i),
    .hd_valid_i(hd_valid_i), .hd_ready_o(hd_ready_o), .hd_bit_i(hd_bit_i),
    .hd_last_i(hd_last_i), .stop_o(stop_o), .done_o(done_o), .reason_o(reason_o),
    .crc_pass_o(crc_pass_o), .snr_exceed_o(snr_exceed_o), .act_iter_o(act_iter_o),
    .cfg_err_o(cfg_err_o)
  );

  typedef struct packed {
    logic [4:0] mn;
    logic [4:0] mx;
    logic       es;
    logic       ec;
    logic       em;
    logic [2:0] need;
    logic [4:0] snr_from;
    logic [7:0] mask;
    logic [1:0] exp_r;
    logic [4:0] exp_it;
    logic [1:0] exp_p;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd1, 5'd8, 1'b0, 1'b1, 1'b0, 3'd1, 5'd0, 8'h01, 2'b10, 5'd1, 2'd1}, // first CRC pass
    '{5'd3, 5'd8, 1'b0, 1'b1, 1'b0, 3'd1, 5'd0, 8'hFF, 2'b10, 5'd3, 2'd1}, // min holds CRC
    '{5'd1, 5'd8, 1'b0, 1'b1, 1'b0, 3'd3, 5'd0, 8'hFB, 2'b10, 5'd6, 2'd1}, // 3 in a row
    '{5'd1, 5'd4, 1'b0, 1'b0, 1'b1, 3'd1, 5'd0, 8'h00, 2'b11, 5'd4, 2'd2}, // limit only
    '{5'd2, 5'd8, 1'b1, 1'b0, 1'b0, 3'd1, 5'd1, 8'h00, 2'b01, 5'd2, 2'd1}, // min holds SNR
    '{5'd3, 5'd8, 1'b1, 1'b1, 1'b1, 3'd1, 5'd1, 8'hFF, 2'b01, 5'd3, 2'd1}, // SNR over CRC
    '{5'd1, 5'd2, 1'b0, 1'b1, 1'b1, 3'd2, 5'd0, 8'h02, 2'b11, 5'd2, 2'd2}, // run short
    '{5'd1, 5'd3, 1'b0, 1'b0, 1'b1, 3'd1, 5'd1, 8'hFF, 2'b11, 5'd3, 2'd2}, // disabled tests
    '{5'd1, 5'd8, 1'b0, 1'b1, 1'b0, 3'd2, 5'd0, 8'h35, 2'b10, 5'd6, 2'd1}, // fail clears run
    '{5'd1, 5'd1, 1'b0, 1'b0, 1'b1, 3'd1, 5'd0, 8'h00, 2'b11, 5'd1, 2'd2}, // limit of 1
    '{5'd1, 5'd8, 1'b1, 1'b0, 1'b1, 3'd1, 5'd4, 8'h00, 2'b01, 5'd4, 2'd1}  // SNR mid-run
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // CRC per R5: MSB-first, feedback from top stage, masked to len bits
  function automatic logic [31:0] ref_crc(input logic [15:0] d, input logic [31:0] poly, input int len);
    logic [31:0] r, m;
    logic fb;
    r = '0;
    m = (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
    for (int i = 15; i >= 0; i--) begin
      fb = r[len-1] ^ d[i];
      r  = ((r << 1) ^ (fb ? poly : 32'd0)) & m;
    end
    return r;
  endfunction

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_pass(input logic [7:0] snr);
    pass_done_i = 1'b1;
    pass_snr_i  = snr;
    @(negedge clk);
    pass_done_i = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] d, input logic [31:0] poly, input int len,
                            input bit bad, input bit gaps);
    logic [63:0] fr;
    int nb;
    nb = 16 + len;
    fr = ({48'd0, d} << len) | {32'd0, ref_crc(d, poly, len)};
    if (bad) fr[len+3] = ~fr[len+3];
    for (int i = nb - 1; i >= 0; i--) begin
      if (gaps && (i == nb - 6 || i == nb - 20)) begin
        hd_valid_i = 1'b0;
        repeat (3) @(negedge clk);
      end
      hd_valid_i = 1'b1;
      hd_bit_i   = fr[i];
      hd_last_i  = (i == 0);
      @(negedge clk);
    end
    hd_valid_i = 1'b0;
    hd_last_i  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    vec_t t;
    string tg;
    int got_it, got_p;
    logic got_done;
    logic [7:0] snr;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R9 stop after reset", stop_o, 0);
    chk("R9 done after reset", done_o, 0);
    chk("R8 reason after reset", reason_o, 0);
    chk("R10 crc_pass after reset", crc_pass_o, 0);
    chk("R13 ready before start", hd_ready_o, 0);
    chk("R1 iter after reset", act_iter_o, 0);

    // R11 configuration error
    min_iter_i = 5'd5; max_iter_i = 5'd3; @(negedge clk);
    chk("R11 min above max", cfg_err_o, 1);
    min_iter_i = 5'd3; max_iter_i = 5'd3; @(negedge clk);
    chk("R11 min equal max", cfg_err_o, 0);

    // R13: bits offered before start are not consumed (no frame result appears)
    send_frame(16'h1234, 32'h07, 8, 1'b0, 1'b0);
    chk("R13 bits ignored while idle", crc_pass_o, 0);

    // Table walk
    crc_poly_i = 32'h07; crc_len_i = 6'd8; snr_thr_i = 8'd100;
    for (int v = 0; v < NV; v++) begin
      t = VECS[v];
      min_iter_i = t.mn; max_iter_i = t.mx;
      en_snr_i = t.es; en_crc_i = t.ec; en_max_i = t.em; crc_need_i = t.need;
      pulse_start();
      chk("R1 iter at start", act_iter_o, 1);
      got_it = 0; got_p = 0; got_done = 1'b0;
      for (int it = 1; it <= 20 && got_p == 0; it++) begin
        send_frame(16'hA5C3 ^ 16'(it), 32'h07, 8, (it <= 8) ? !t.mask[it-1] : 1'b1, 1'b0);
        snr = (t.snr_from != 0 && it >= int'(t.snr_from)) ? 8'd150 : 8'd10;
        do_pass(snr);
        if (stop_o) begin got_it = it; got_p = 1; got_done = done_o; end
        else begin
          do_pass(snr);
          if (stop_o) begin got_it = it; got_p = 2; got_done = done_o; end
        end
      end
      if (t.mn > 1)              tg = "R3";
      else if (t.exp_r == 2'b01) tg = "R2";
      else if (t.exp_r == 2'b10) tg = "R7";
      else                       tg = "R4";
      chk($sformatf("R8 reason vec %0d", v), reason_o, t.exp_r);
      chk($sformatf("%s stop iteration vec %0d", tg, v), got_it, t.exp_it);
      chk($sformatf("R1 stop pass vec %0d", v), got_p, t.exp_p);
      chk($sformatf("R9 done at stop vec %0d", v), got_done, 1);
      chk($sformatf("R13 ready after stop vec %0d", v), hd_ready_o, 0);
      @(negedge clk);
      chk($sformatf("R9 done single vec %0d", v), done_o, 0);
    end

    // R9: pass pulses after a stop are ignored
    do_pass(8'd200);
    chk("R9 iter frozen after stop", act_iter_o, 4);
    chk("R9 reason held after stop", reason_o, 2'b01);
    chk("R9 no second done", done_o, 0);

    // R1 / R2 / R10: threshold boundary and iteration stepping
    min_iter_i = 5'd1; max_iter_i = 5'd8;
    en_snr_i = 1'b1; en_crc_i = 1'b0; en_max_i = 1'b0; snr_thr_i = 8'd100;
    pulse_start();
    chk("R13 ready after start", hd_ready_o, 1);
    do_pass(8'd100);
    chk("R2 equal threshold no stop", stop_o, 0);
    chk("R10 snr_exceed low at equal", snr_exceed_o, 0);
    chk("R1 iter after one pass", act_iter_o, 1);
    do_pass(8'd40);
    chk("R1 iter after two passes", act_iter_o, 2);
    do_pass(8'd101);
    chk("R2 above threshold stops", stop_o, 1);
    chk("R2 reason snr", reason_o, 2'b01);
    chk("R10 snr_exceed high", snr_exceed_o, 1);

    // R12: disabled tests never stop
    en_snr_i = 1'b0; en_crc_i = 1'b0; en_max_i = 1'b0; max_iter_i = 5'd1;
    pulse_start();
    for (int k = 0; k < 3; k++) begin
      send_frame(16'h0F0F, 32'h07, 8, 1'b0, 1'b0);
      do_pass(8'd250);
      do_pass(8'd250);
    end
    chk("R12 no stop with tests disabled", stop_o, 0);
    chk("R12 iteration kept counting", act_iter_o, 4);

    // R5 / R6: 16-bit CRC split into sub-blocks with idle gaps
    crc_poly_i = 32'h1021; crc_len_i = 6'd16;
    send_frame(16'hBEEF, 32'h1021, 16, 1'b0, 1'b1);
    chk("R6 sub-block chain passes", crc_pass_o, 1);
    send_frame(16'hBEEF, 32'h1021, 16, 1'b1, 1'b1);
    chk("R5 corrupted frame fails", crc_pass_o, 0);
    send_frame(16'h1357, 32'h1021, 16, 1'b0, 1'b0);
    chk("R5 register cleared between frames", crc_pass_o, 1);

    // R5: full 32-bit length
    crc_poly_i = 32'h04C1_1DB7; crc_len_i = 6'd32;
    send_frame(16'hC0DE, 32'h04C1_1DB7, 32, 1'b0, 1'b1);
    chk("R5 32-bit frame passes", crc_pass_o, 1);
    send_frame(16'hC0DE, 32'h04C1_1DB7, 32, 1'b1, 1'b0);
    chk("R5 32-bit corrupted fails", crc_pass_o, 0);

    // R10: start clears status
    pulse_start();
    chk("R10 crc_pass cleared by start", crc_pass_o, 0);
    chk("R10 snr_exceed cleared by start", snr_exceed_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule